// File: doc/BRIEF.md
# Four-Lane 66-Bit Block Receive Deframer

This block sits behind a PCS-level receive port that delivers a wide word of four 66-bit blocks per clock. Each clock where the port's enable is high carries a fresh word. The port cannot be stalled, so the block takes one word on every enabled cycle with no ready signal. It cuts the word into its blocks and strips each block's 2-bit sync header from its 64-bit payload. It then tags every block as data, control, idle or invalid, and registers the payloads and tags with one cycle of latency.

A marker flag travels with the word and marks cycles that hold an alignment marker. Such a cycle is reported as a marker and is kept out of the user-traffic counts. Four saturating counters keep totals of valid blocks, idle blocks, marker cycles and header errors, and a synchronous clear resets them. A receive-status input says whether reception is valid. Its registered inverse asks downstream logic to generate a local fault.

Top module: `blk_deframer_rx`

## Requirements
- R1: Block k of `word_data` occupies bits 66k+65..66k. Its header is bits 66k+65..66k+64. Its payload, bits 66k+63..66k, appears on `out_payload[64k+63:64k]`, and its tag appears on `out_kind[2k+1:2k]`.
- R2: Each output register takes the word from the edge where `word_ena` is sampled high, so outputs update one cycle later. `out_vld` equals `word_ena` delayed by one cycle. No ready signal exists and every enabled word is taken.
- R3: A word presented while `word_ena` is low is ignored. In the next cycle `out_vld` is 0, `out_payload`, `out_kind` and `out_am` keep their values, and no counter changes.
- R4: Header 2'b01 gives tag 0 (data). Header 2'b10 gives tag 1 (control) unless R5 applies.
- R5: A block with header 2'b10 whose payload bits 7:0 equal `IDLE_TYPE` (default 8'h1E) and whose payload bits 63:8 are all zero gives tag 2 (idle). A header other than 2'b10 never gives the idle tag.
- R6: Headers 2'b00 and 2'b11 give tag 3 (invalid). On an enabled non-marker cycle, each such block adds one to `cnt_hdr_err`.
- R7: An enabled cycle with `word_am` high sets `out_am` on the next cycle, together with `out_vld`, and adds one to `cnt_am`. Its blocks add nothing to `cnt_blocks`, `cnt_idle` or `cnt_hdr_err`. The `word_am` input is ignored when `word_ena` is low.
- R8: On an enabled non-marker cycle, `cnt_blocks` grows by the number of blocks whose header is 2'b01 or 2'b10, and `cnt_idle` grows by the number of idle-tagged blocks.
- R9: Each counter stops at 2^CNT_W-1 and does not wrap.
- R10: When `cnt_clr` is high at a clock edge, all four counters read 0 after that edge, even if an increment is due in the same cycle.
- R11: `lf_req` equals the inverse of `link_up` delayed by one cycle.
- R12: While `rst_n` is low, `out_vld`, `out_am`, `lf_req`, `out_kind`, `out_payload` and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_ena | input | 1 | Qualifies `word_data` on this cycle |
| word_data | input | NUM_BLK*66 | Four 66-bit blocks, block 0 in the low bits |
| word_am | input | 1 | Current word is an alignment-marker cycle |
| link_up | input | 1 | Receive status: 1 when reception is valid |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| out_vld | output | 1 | Registered outputs hold a new word |
| out_am | output | 1 | Registered word was a marker cycle |
| out_kind | output | NUM_BLK*2 | Per-block tag: 0 data, 1 control, 2 idle, 3 invalid |
| out_payload | output | NUM_BLK*64 | Per-block 64-bit payload |
| lf_req | output | 1 | Request for locally generated local fault |
| cnt_blocks | output | CNT_W | Valid-header block total |
| cnt_idle | output | CNT_W | Idle block total |
| cnt_am | output | CNT_W | Marker cycle total |
| cnt_hdr_err | output | CNT_W | Invalid-header block total |

## Verification
The bench builds the block with the default four blocks per word and with `CNT_W` reduced to 6. With that width the counters top out at 63, so twenty all-data words drive `cnt_blocks` into saturation and keep it there. The vector table mixes headers, idle and non-idle control payloads and marker cycles across all four lanes. A running model of the counters is checked after each vector.

// File: rtl/rxd_pkg.sv
// Package rxd_pkg
// Shared widths, header codes and the block tag type for the receive deframer.
package rxd_pkg;
    localparam int HDR_W = 2;
    localparam int PAY_W = 64;
    localparam int BLK_W = HDR_W + PAY_W;

    localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_CTRL = 2'd1,
        KIND_IDLE = 2'd2,
        KIND_BAD  = 2'd3
    } blk_kind_e;
endpackage

// File: rtl/blk_classify.sv
// Module blk_classify
// Splits one 66-bit block into header and payload and tags it.
// Assumes the header sits in the two top bits. Purely combinational.
module blk_classify
    import rxd_pkg::*;
#(
    parameter logic [7:0] IDLE_TYPE = 8'h1E
) (
    input  logic [BLK_W-1:0] blk,
    output blk_kind_e        kind,
    output logic [PAY_W-1:0] payload,
    output logic             hdr_ok,
    output logic             is_idle,
    output logic             is_bad
);
    logic [HDR_W-1:0] hdr;

    assign hdr     = blk[BLK_W-1 -: HDR_W];
    assign payload = blk[PAY_W-1:0];

    // Decode the header and spot idle control blocks.
    always_comb begin
        hdr_ok  = (hdr == HDR_DATA) || (hdr == HDR_CTRL);
        is_bad  = !hdr_ok;
        is_idle = (hdr == HDR_CTRL) && (payload[7:0] == IDLE_TYPE)
                  && (payload[PAY_W-1:8] == '0);
        if (is_bad)
            kind = KIND_BAD;
        else if (is_idle)
            kind = KIND_IDLE;
        else if (hdr == HDR_CTRL)
            kind = KIND_CTRL;
        else
            kind = KIND_DATA;
    end
endmodule

// File: rtl/sat_accum.sv
// Module sat_accum
// Saturating accumulator with a synchronous clear that wins over an add.
// Assumes INC_W <= W.
module sat_accum #(
    parameter int W     = 16,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     cnt
);
    logic [W:0] sum;

    // Widened sum so that an overflow shows in the top bit.
    assign sum = {1'b0, cnt} + {{(W + 1 - INC_W){1'b0}}, inc};

    // Accumulate, clamp at the top, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (en)
            cnt <= sum[W] ? '1 : sum[W-1:0];
    end
endmodule

// File: rtl/blk_deframer_rx.sv
// Module blk_deframer_rx
// Receive deframer for a word of NUM_BLK 66-bit blocks. It takes one word on
// every enabled cycle (no backpressure), registers per-block tags and payloads
// with one cycle of latency, keeps saturating totals and requests a local
// fault when reception is lost. Assumes word_am is meaningful only with word_ena.
module blk_deframer_rx
    import rxd_pkg::*;
#(
    parameter int         NUM_BLK   = 4,
    parameter int         CNT_W     = 16,
    parameter logic [7:0] IDLE_TYPE = 8'h1E
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     word_ena,
    input  logic [NUM_BLK*BLK_W-1:0] word_data,
    input  logic                     word_am,
    input  logic                     link_up,
    input  logic                     cnt_clr,
    output logic                     out_vld,
    output logic                     out_am,
    output logic [NUM_BLK*2-1:0]     out_kind,
    output logic [NUM_BLK*PAY_W-1:0] out_payload,
    output logic                     lf_req,
    output logic [CNT_W-1:0]         cnt_blocks,
    output logic [CNT_W-1:0]         cnt_idle,
    output logic [CNT_W-1:0]         cnt_am,
    output logic [CNT_W-1:0]         cnt_hdr_err
);
    localparam int INC_W = $clog2(NUM_BLK + 1);

    logic [NUM_BLK*2-1:0]     kind_c;
    logic [NUM_BLK*PAY_W-1:0] pay_c;
    logic [NUM_BLK-1:0]       ok_v, idle_v, bad_v;
    logic [INC_W-1:0]         n_ok, n_idle, n_bad;
    logic                     user_cyc, am_cyc;

    // One classifier per lane.
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_lane
        blk_kind_e lane_kind;
        blk_classify #(.IDLE_TYPE(IDLE_TYPE)) u_cls (
            .blk     (word_data[g*BLK_W +: BLK_W]),
            .kind    (lane_kind),
            .payload (pay_c[g*PAY_W +: PAY_W]),
            .hdr_ok  (ok_v[g]),
            .is_idle (idle_v[g]),
            .is_bad  (bad_v[g])
        );
        assign kind_c[g*2 +: 2] = lane_kind;
    end

    // Population counts of the per-lane flags.
    always_comb begin
        n_ok   = '0;
        n_idle = '0;
        n_bad  = '0;
        for (int i = 0; i < NUM_BLK; i++) begin
            n_ok   = n_ok   + INC_W'(ok_v[i]);
            n_idle = n_idle + INC_W'(idle_v[i]);
            n_bad  = n_bad  + INC_W'(bad_v[i]);
        end
    end

    assign user_cyc = word_ena && !word_am;
    assign am_cyc   = word_ena && word_am;

    // Valid strobe and fault request follow their inputs by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            lf_req  <= 1'b0;
        end else begin
            out_vld <= word_ena;
            lf_req  <= !link_up;
        end
    end

    // Output word registers load only on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_am      <= 1'b0;
            out_kind    <= '0;
            out_payload <= '0;
        end else if (word_ena) begin
            out_am      <= word_am;
            out_kind    <= kind_c;
            out_payload <= pay_c;
        end
    end

    sat_accum #(.W(CNT_W), .INC_W(INC_W)) u_cnt_blocks (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(user_cyc),
        .inc(n_ok), .cnt(cnt_blocks)
    );
    sat_accum #(.W(CNT_W), .INC_W(INC_W)) u_cnt_idle (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(user_cyc),
        .inc(n_idle), .cnt(cnt_idle)
    );
    sat_accum #(.W(CNT_W), .INC_W(INC_W)) u_cnt_err (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(user_cyc),
        .inc(n_bad), .cnt(cnt_hdr_err)
    );
    sat_accum #(.W(CNT_W), .INC_W(INC_W)) u_cnt_am (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(am_cyc),
        .inc(INC_W'(1)), .cnt(cnt_am)
    );
endmodule

// File: rtl/rxd_chk.sv
// Module rxd_chk
// Property checker for blk_deframer_rx, attached through bind below.
module rxd_chk #(
    parameter int NUM_BLK = 4,
    parameter int CNT_W   = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  word_ena,
    input logic                  word_am,
    input logic                  link_up,
    input logic                  cnt_clr,
    input logic                  out_vld,
    input logic                  out_am,
    input logic [NUM_BLK*2-1:0]  out_kind,
    input logic [NUM_BLK*64-1:0] out_payload,
    input logic                  lf_req,
    input logic [CNT_W-1:0]      cnt_blocks,
    input logic [CNT_W-1:0]      cnt_idle,
    input logic [CNT_W-1:0]      cnt_am,
    input logic [CNT_W-1:0]      cnt_hdr_err
);
    a_r2_vld_follows_ena: assert property (@(posedge clk) disable iff (!rst_n)
        word_ena |=> out_vld);
    a_r3_no_vld_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !word_ena |=> !out_vld);
    a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !word_ena |=> ($stable(out_payload) && $stable(out_kind) && $stable(out_am)));
    a_r7_marker_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ena && word_am) |=> (out_am && out_vld));
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && cnt_blocks == '1) |=> (cnt_blocks == '1));
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_blocks == '0 && cnt_idle == '0 && cnt_am == '0 && cnt_hdr_err == '0));
    a_r11_fault_req: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> lf_req);
    a_r11_fault_drop: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> !lf_req);
endmodule

bind blk_deframer_rx rxd_chk #(.NUM_BLK(NUM_BLK), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_ena(word_ena), .word_am(word_am),
    .link_up(link_up), .cnt_clr(cnt_clr), .out_vld(out_vld), .out_am(out_am),
    .out_kind(out_kind), .out_payload(out_payload), .lf_req(lf_req),
    .cnt_blocks(cnt_blocks), .cnt_idle(cnt_idle), .cnt_am(cnt_am),
    .cnt_hdr_err(cnt_hdr_err)
);

// File: tb/blk_deframer_rx_tb.sv
`timescale 1ns/1ps
module blk_deframer_rx_tb;
    localparam int NB = 4;
    localparam int CW = 6;
    localparam logic [CW-1:0] CMAX = '1;

    logic clk = 1'b0;
    logic rst_n, word_ena, word_am, link_up, cnt_clr;
    logic [NB*66-1:0] word_data;
    logic out_vld, out_am, lf_req;
    logic [NB*2-1:0]  out_kind;
    logic [NB*64-1:0] out_payload;
    logic [CW-1:0] cnt_blocks, cnt_idle, cnt_am, cnt_hdr_err;

    int n_chk = 0, n_err = 0;
    int m_blk = 0, m_idle = 0, m_am = 0, m_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    blk_deframer_rx #(.NUM_BLK(NB), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .word_ena(word_ena), .word_data(word_data),
        .word_am(word_am), .link_up(link_up), .cnt_clr(cnt_clr),
        .out_vld(out_vld), .out_am(out_am), .out_kind(out_kind),
        .out_payload(out_payload), .lf_req(lf_req), .cnt_blocks(cnt_blocks),
        .cnt_idle(cnt_idle), .cnt_am(cnt_am), .cnt_hdr_err(cnt_hdr_err)
    );

    // Vector: {hdrs[7:0], idle_lanes[3:0], am, exp_kind[7:0]}
    localparam logic [20:0] VEC [8] = '{
        {8'h55, 4'b0000, 1'b0, 8'h00},
        {8'hAA, 4'b1111, 1'b0, 8'hAA},
        {8'hAA, 4'b0101, 1'b0, 8'h66},
        {8'h36, 4'b0001, 1'b0, 8'hF2},
        {8'h55, 4'b0000, 1'b1, 8'h00},
        {8'hFF, 4'b0000, 1'b0, 8'hFF},
        {8'hA9, 4'b0001, 1'b0, 8'h54},
        {8'h36, 4'b0000, 1'b1, 8'hF1}
    };

    function automatic logic [63:0] lane_pay(int k, bit idle);
        return idle ? {56'h0, 8'h1E} : {8'(k + 1), 48'h123456789ABC, 8'h1E};
    endfunction

    function automatic logic [NB*66-1:0] build(logic [7:0] hdrs, logic [3:0] idl);
        logic [NB*66-1:0] w;
        for (int k = 0; k < NB; k++)
            w[k*66 +: 66] = {hdrs[k*2 +: 2], lane_pay(k, idl[k])};
        return w;
    endfunction

    function automatic int sat(int v);
        return (v > int'(CMAX)) ? int'(CMAX) : v;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_cnts(string req);
        check({req, " cnt_blocks"}, 64'(cnt_blocks), 64'(m_blk));
        check({req, " cnt_idle"}, 64'(cnt_idle), 64'(m_idle));
        check({req, " cnt_am"}, 64'(cnt_am), 64'(m_am));
        check({req, " cnt_hdr_err"}, 64'(cnt_hdr_err), 64'(m_err));
    endtask

    // Drive at a falling edge; outputs are read at the following falling edge.
    task automatic step(logic ena, logic [7:0] hdrs, logic [3:0] idl, logic am);
        word_ena  = ena;
        word_am   = am;
        word_data = build(hdrs, idl);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; word_ena = 1'b1; word_am = 1'b1; link_up = 1'b0;
        cnt_clr = 1'b0; word_data = build(8'h55, 4'b0000);
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 out_vld", 64'(out_vld), 64'd0);
        check("R12 out_am", 64'(out_am), 64'd0);
        check("R12 lf_req", 64'(lf_req), 64'd0);
        check("R12 out_kind", 64'(out_kind), 64'd0);
        check("R12 out_payload", out_payload[63:0], 64'd0);
        check_cnts("R12");
        link_up = 1'b1; word_ena = 1'b0; word_am = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R4 R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            logic [7:0] hd, ek;
            logic [3:0] il;
            logic am;
            {hd, il, am, ek} = VEC[v];
            step(1'b1, hd, il, am);
            if (!am) begin
                for (int k = 0; k < NB; k++) begin
                    if (hd[k*2 +: 2] == 2'b01 || hd[k*2 +: 2] == 2'b10) m_blk++;
                    if (ek[k*2 +: 2] == 2'd2) m_idle++;
                    if (ek[k*2 +: 2] == 2'd3) m_err++;
                end
            end else m_am++;
            m_blk = sat(m_blk); m_idle = sat(m_idle); m_err = sat(m_err); m_am = sat(m_am);
            check("R2 out_vld", 64'(out_vld), 64'd1);
            check("R4 R5 R6 out_kind", 64'(out_kind), 64'(ek));
            check("R7 out_am", 64'(out_am), 64'(am));
            for (int k = 0; k < NB; k++)
                check("R1 lane payload", out_payload[k*64 +: 64], lane_pay(k, il[k]));
            check_cnts("R8");
        end

        // R3: disabled word with a marker flag and bad headers is ignored
        step(1'b0, 8'h00, 4'b1111, 1'b1);
        check("R3 out_vld", 64'(out_vld), 64'd0);
        check("R3 out_kind held", 64'(out_kind), 64'hF1);
        check("R3 out_am held", 64'(out_am), 64'd1);
        check("R3 payload held", out_payload[127:64], lane_pay(1, 1'b0));
        check_cnts("R3");

        // R5: control header, zero body but other type byte is plain control
        word_ena = 1'b1; word_am = 1'b0;
        word_data = build(8'hAA, 4'b1111);
        word_data[7:0] = 8'h4B;
        @(negedge clk);
        m_blk = sat(m_blk + 4); m_idle = sat(m_idle + 3);
        check("R5 non-idle type", 64'(out_kind), 64'hA9);
        check_cnts("R5");

        // R10: clear wins over a same-cycle increment
        cnt_clr = 1'b1;
        step(1'b1, 8'h36, 4'b0000, 1'b0);
        cnt_clr = 1'b0;
        m_blk = 0; m_idle = 0; m_am = 0; m_err = 0;
        check_cnts("R10");

        // R9: push cnt_blocks past its limit
        for (int i = 0; i < 20; i++) step(1'b1, 8'h55, 4'b0000, 1'b0);
        check("R9 saturate", 64'(cnt_blocks), 64'(CMAX));
        step(1'b1, 8'h55, 4'b0000, 1'b0);
        check("R9 stays", 64'(cnt_blocks), 64'(CMAX));

        // R11: fault request follows status
        word_ena = 1'b0;
        link_up = 1'b0;
        @(negedge clk);
        check("R11 lf_req set", 64'(lf_req), 64'd1);
        link_up = 1'b1;
        @(negedge clk);
        check("R11 lf_req clear", 64'(lf_req), 64'd0);

        // R2: back-to-back enabled words all land
        step(1'b1, 8'hFF, 4'b0000, 1'b0);
        check("R2 b2b first", 64'(out_kind), 64'hFF);
        step(1'b1, 8'h55, 4'b0000, 1'b0);
        check("R2 b2b second", 64'(out_kind), 64'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule